// File: doc/BRIEF.md
# IDE Programmed-I/O Cycle Sequencer

This block turns host register requests into ATA programmed-I/O bus cycles for one channel that carries two drives. A request names the drive, the register block (command or control), the 3-bit register index, the direction and, for writes, the data word. The block drives the address lines and the chip select for the request. It asserts the read or write strobe for the active time, optionally stretches the strobe until the drive raises IORDY, and then enforces a recovery interval before the next cycle may start.

Each drive has its own timing controls, all counted in clock cycles. There is a 2-bit active-time code, a 2-bit recovery code, a fast-timing enable, a "fast timing for DMA only" enable, an IORDY sampling enable and a posting enable. A channel-wide enable lets non-data registers use the fast timings as well. When no control is set, every cycle uses the slow compatible timing.

For reads, the block captures the drive's data word when the strobe ends and returns it with a one-cycle done pulse. A write to the data port may be posted: its done pulse then arrives before the strobe is issued.

Top module: `ide_pio_seq`

## Requirements
- R1: While reset is low and right after it is released, both strobes and both chip selects are high, done_o is low and req_ready_o is high.
- R2: The register index appears on da_o, and the selected chip select is low (cs0_no for command block, req_ctl_i=0; cs1_no for control block, req_ctl_i=1), one clock before the strobe falls. Both stay unchanged during the clock after the strobe rises. Only one strobe is low at a time.
- R3: A cycle on compatible timing holds its strobe low for 12 clocks when IORDY sampling is off.
- R4: A cycle on fast timing holds its strobe low for 5, 4, 3 or 2 clocks for active codes 00, 01, 10 and 11 of the addressed drive.
- R5: When a request is already waiting, the strobe stays high for recovery+2 clocks between two cycles. Recovery is 10 on compatible timing, and 4, 3, 2 or 1 on fast timing for recovery codes 00, 01, 10 and 11.
- R6: With IORDY sampling enabled for the drive, the strobe stays low past the active time until IORDY is sampled high. With sampling disabled, IORDY has no effect on the strobe width.
- R7: The data port is command block, index 0. Accesses to it use fast timing only when the drive's fast enable is set and its DMA-only enable is clear.
- R8: Accesses to any other register use fast timing, with the addressed drive's codes, only when the channel's fast non-data enable is set. Otherwise they use compatible timing.
- R9: A non-posted cycle raises done_o for exactly one clock, in the first clock after the strobe rises. For reads, rdata_o then holds dd_i as sampled at the strobe's last low clock.
- R10: A write to the data port of a drive whose posting enable is set is posted. Its done_o pulse arrives in the clock after acceptance, before the strobe falls. Writes to non-data registers are never posted.
- R11: req_ready_o is high only when no cycle is in progress. During a write cycle dd_oe_o is high and dd_o carries the request's data. During a read cycle dd_oe_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_drive_i | input | 1 | Drive select |
| req_ctl_i | input | 1 | 0 = command block, 1 = control block |
| req_addr_i | input | 3 | Register index |
| req_wdata_i | input | 16 | Write data |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 16 | Read data, valid with done_o |
| act_code_i | input | 4 | Per-drive fast active-time code, 2 bits each |
| rcv_code_i | input | 4 | Per-drive fast recovery code, 2 bits each |
| fast_en_i | input | 2 | Per-drive fast timing enable |
| dma_only_i | input | 2 | Per-drive: fast timing for DMA only |
| iordy_en_i | input | 2 | Per-drive IORDY sampling enable |
| post_en_i | input | 2 | Per-drive data-port write posting enable |
| fast_nd_i | input | 1 | Fast timing for non-data registers |
| ior_no | output | 1 | Read strobe, active low |
| iow_no | output | 1 | Write strobe, active low |
| cs0_no | output | 1 | Command block select, active low |
| cs1_no | output | 1 | Control block select, active low |
| da_o | output | 3 | Register address lines |
| dd_o | output | 16 | Drive data out |
| dd_oe_o | output | 1 | Drive data output enable |
| dd_i | input | 16 | Drive data in |
| iordy_i | input | 1 | Drive ready |

## Verification
Acceptance happens at a clock edge. The address and select change at that edge, the strobe falls one clock later, and it rises after the active time plus any IORDY wait. A non-posted done pulse and its read data follow the rise at the same edge, and a posted done pulse follows the acceptance edge. The next strobe can fall no sooner than recovery+2 clocks after the rise. The driver works out each expected width, gap, address, data and done timing from the drive controls before it raises valid, and queues them. The monitor samples on the falling clock edge and compares at the edges where the strobe falls, where it rises and where done_o is high. The bench's drive model holds IORDY low for a random number of clocks and feeds read data from the queued item, so each expected width is max(active, hold) with sampling enabled and the plain active time without it.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACT,
    ST_WAIT,
    ST_RCV
  } pio_state_e;

endpackage

// File: rtl/ide_pio_tsel.sv
// Per-request timing selection: data port vs non-data, fast vs compatible.
module ide_pio_tsel #(
  parameter int NUM_DRV      = 2,
  parameter int DRV_W        = 1,
  parameter int AW           = 3,
  parameter int CNT_W        = 4,
  parameter int COMPAT_ACT   = 12,
  parameter int COMPAT_RCV   = 10,
  parameter int FAST_ACT_MAX = 5,
  parameter int FAST_RCV_MAX = 4
) (
  input  logic [DRV_W-1:0]          drv_i,
  input  logic [AW-1:0]             addr_i,
  input  logic                      ctl_i,
  input  logic                      write_i,
  input  logic [NUM_DRV-1:0][1:0]   act_code_i,
  input  logic [NUM_DRV-1:0][1:0]   rcv_code_i,
  input  logic [NUM_DRV-1:0]        fast_en_i,
  input  logic [NUM_DRV-1:0]        dma_only_i,
  input  logic [NUM_DRV-1:0]        iordy_en_i,
  input  logic [NUM_DRV-1:0]        post_en_i,
  input  logic                      fast_nd_i,
  output logic [CNT_W-1:0]          act_o,
  output logic [CNT_W-1:0]          rcv_o,
  output logic                      iordy_en_o,
  output logic                      posted_o
);

  logic [NUM_DRV-1:0][CNT_W-1:0] fast_act;
  logic [NUM_DRV-1:0][CNT_W-1:0] fast_rcv;
  logic [NUM_DRV-1:0]            data_fast;

  for (genvar g = 0; g < NUM_DRV; g++) begin : g_drv
    assign fast_act[g]  = CNT_W'(FAST_ACT_MAX - int'(act_code_i[g]));
    assign fast_rcv[g]  = CNT_W'(FAST_RCV_MAX - int'(rcv_code_i[g]));
    assign data_fast[g] = fast_en_i[g] & ~dma_only_i[g];
  end

  logic is_data;
  logic use_fast;

  always_comb begin
    is_data    = !ctl_i && (addr_i == '0);
    use_fast   = is_data ? data_fast[drv_i] : fast_nd_i;
    act_o      = use_fast ? fast_act[drv_i] : CNT_W'(COMPAT_ACT);
    rcv_o      = use_fast ? fast_rcv[drv_i] : CNT_W'(COMPAT_RCV);
    iordy_en_o = iordy_en_i[drv_i];
    posted_o   = write_i && is_data && post_en_i[drv_i];
  end

endmodule

// File: rtl/ide_pio_fsm.sv
// Cycle sequencer: setup, strobe active, IORDY wait, recovery.
module ide_pio_fsm
  import ide_pio_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] act_i,
  input  logic [CNT_W-1:0] rcv_i,
  input  logic             iordy_en_i,
  input  logic             posted_i,
  input  logic             write_i,
  input  logic             iordy_i,
  output logic             ready_o,
  output logic             cyc_o,
  output logic             strb_o,
  output logic             end_o,
  output logic             wr_o,
  output logic             done_o
);

  pio_state_e       st_q;
  logic [CNT_W-1:0] cnt_q, act_q, rcv_q;
  logic             iordy_en_q, posted_q, wr_q, done_q;
  logic             cnt_zero, end_act;

  assign cnt_zero = (cnt_q == '0);
  assign end_act  = ((st_q == ST_ACT) && cnt_zero && (!iordy_en_q || iordy_i)) ||
                    ((st_q == ST_WAIT) && iordy_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      act_q      <= '0;
      rcv_q      <= '0;
      iordy_en_q <= 1'b0;
      posted_q   <= 1'b0;
      wr_q       <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= (end_act && !posted_q) || (start_i && posted_i);
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q       <= ST_SETUP;
          act_q      <= act_i;
          rcv_q      <= rcv_i;
          iordy_en_q <= iordy_en_i;
          posted_q   <= posted_i;
          wr_q       <= write_i;
        end
        ST_SETUP: begin
          st_q  <= ST_ACT;
          cnt_q <= act_q - CNT_W'(1);
        end
        ST_ACT: begin
          if (!cnt_zero) begin
            cnt_q <= cnt_q - CNT_W'(1);
          end else if (end_act) begin
            st_q  <= ST_RCV;
            cnt_q <= rcv_q - CNT_W'(1);
          end else begin
            st_q <= ST_WAIT;
          end
        end
        ST_WAIT: if (iordy_i) begin
          st_q  <= ST_RCV;
          cnt_q <= rcv_q - CNT_W'(1);
        end
        ST_RCV: begin
          if (!cnt_zero) cnt_q <= cnt_q - CNT_W'(1);
          else           st_q  <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o = (st_q == ST_IDLE);
  assign cyc_o   = (st_q != ST_IDLE);
  assign strb_o  = (st_q == ST_ACT) || (st_q == ST_WAIT);
  assign end_o   = end_act;
  assign wr_o    = wr_q;
  assign done_o  = done_q;

endmodule

// File: rtl/ide_pio_seq.sv
module ide_pio_seq #(
  parameter int NUM_DRV      = 2,
  parameter int AW           = 3,
  parameter int DW           = 16,
  parameter int CNT_W        = 4,
  parameter int COMPAT_ACT   = 12,
  parameter int COMPAT_RCV   = 10,
  parameter int FAST_ACT_MAX = 5,
  parameter int FAST_RCV_MAX = 4,
  localparam int DRV_W       = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic                    req_write_i,
  input  logic [DRV_W-1:0]        req_drive_i,
  input  logic                    req_ctl_i,
  input  logic [AW-1:0]           req_addr_i,
  input  logic [DW-1:0]           req_wdata_i,
  output logic                    done_o,
  output logic [DW-1:0]           rdata_o,
  input  logic [NUM_DRV-1:0][1:0] act_code_i,
  input  logic [NUM_DRV-1:0][1:0] rcv_code_i,
  input  logic [NUM_DRV-1:0]      fast_en_i,
  input  logic [NUM_DRV-1:0]      dma_only_i,
  input  logic [NUM_DRV-1:0]      iordy_en_i,
  input  logic [NUM_DRV-1:0]      post_en_i,
  input  logic                    fast_nd_i,
  output logic                    ior_no,
  output logic                    iow_no,
  output logic                    cs0_no,
  output logic                    cs1_no,
  output logic [AW-1:0]           da_o,
  output logic [DW-1:0]           dd_o,
  output logic                    dd_oe_o,
  input  logic [DW-1:0]           dd_i,
  input  logic                    iordy_i
);

  logic [CNT_W-1:0] sel_act, sel_rcv;
  logic             sel_iordy, sel_posted;
  logic             ready, start, cyc, strb, end_act, wr;
  logic [AW-1:0]    da_q;
  logic             ctl_q;
  logic [DW-1:0]    wdata_q, rdata_q;

  assign start = req_valid_i && ready;

  ide_pio_tsel #(
    .NUM_DRV(NUM_DRV), .DRV_W(DRV_W), .AW(AW), .CNT_W(CNT_W),
    .COMPAT_ACT(COMPAT_ACT), .COMPAT_RCV(COMPAT_RCV),
    .FAST_ACT_MAX(FAST_ACT_MAX), .FAST_RCV_MAX(FAST_RCV_MAX)
  ) u_tsel (
    .drv_i      (req_drive_i),
    .addr_i     (req_addr_i),
    .ctl_i      (req_ctl_i),
    .write_i    (req_write_i),
    .act_code_i (act_code_i),
    .rcv_code_i (rcv_code_i),
    .fast_en_i  (fast_en_i),
    .dma_only_i (dma_only_i),
    .iordy_en_i (iordy_en_i),
    .post_en_i  (post_en_i),
    .fast_nd_i  (fast_nd_i),
    .act_o      (sel_act),
    .rcv_o      (sel_rcv),
    .iordy_en_o (sel_iordy),
    .posted_o   (sel_posted)
  );

  ide_pio_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .act_i      (sel_act),
    .rcv_i      (sel_rcv),
    .iordy_en_i (sel_iordy),
    .posted_i   (sel_posted),
    .write_i    (req_write_i),
    .iordy_i    (iordy_i),
    .ready_o    (ready),
    .cyc_o      (cyc),
    .strb_o     (strb),
    .end_o      (end_act),
    .wr_o       (wr),
    .done_o     (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      da_q    <= '0;
      ctl_q   <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (start) begin
        da_q    <= req_addr_i;
        ctl_q   <= req_ctl_i;
        wdata_q <= req_wdata_i;
      end
      // capture on the strobe's deasserting edge
      if (end_act) rdata_q <= dd_i;
    end
  end

  assign req_ready_o = ready;
  assign ior_no      = !(strb && !wr);
  assign iow_no      = !(strb && wr);
  assign cs0_no      = !(cyc && !ctl_q);
  assign cs1_no      = !(cyc && ctl_q);
  assign da_o        = da_q;
  assign dd_o        = wdata_q;
  assign dd_oe_o     = cyc && wr;
  assign rdata_o     = rdata_q;

endmodule

// File: rtl/ide_pio_chk.sv
module ide_pio_chk #(
  parameter int AW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ior_no,
  input logic          iow_no,
  input logic          cs0_no,
  input logic          cs1_no,
  input logic [AW-1:0] da_o,
  input logic          done_o,
  input logic          req_ready_o
);

  logic       stb;
  logic [7:0] lo_cnt, hi_cnt;

  assign stb = ior_no && iow_no;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt <= '0;
      hi_cnt <= '1;
    end else if (!stb) begin
      lo_cnt <= (lo_cnt == '1) ? lo_cnt : lo_cnt + 8'd1;
      hi_cnt <= '0;
    end else begin
      lo_cnt <= '0;
      hi_cnt <= (hi_cnt == '1) ? hi_cnt : hi_cnt + 8'd1;
    end
  end

  assert_strb_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!ior_no && !iow_no));

  assert_addr_setup_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stb) |-> ($past(!cs0_no || !cs1_no) && $stable(da_o)));

  assert_addr_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stb) |-> ((!cs0_no || !cs1_no) && $stable(da_o)));

  assert_min_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stb) |-> (lo_cnt >= 8'd2));

  assert_min_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stb) |-> (hi_cnt >= 8'd3));

  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_ready_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (stb && cs0_no && cs1_no));

endmodule

bind ide_pio_seq ide_pio_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ior_no      (ior_no),
  .iow_no      (iow_no),
  .cs0_no      (cs0_no),
  .cs1_no      (cs1_no),
  .da_o        (da_o),
  .done_o      (done_o),
  .req_ready_o (req_ready_o)
);

// File: tb/ide_pio_seq_test.sv
`timescale 1ns/1ps
module ide_pio_seq_test;
  localparam int NUM_DRV = 2;
  localparam int AW = 3;
  localparam int DW = 16;

  logic clk_i = 1'b0;
  always #2 clk_i = ~clk_i;

  logic                    rst_ni;
  logic                    req_valid_i, req_ready_o, req_write_i, req_ctl_i;
  logic [0:0]              req_drive_i;
  logic [AW-1:0]           req_addr_i;
  logic [DW-1:0]           req_wdata_i;
  logic                    done_o;
  logic [DW-1:0]           rdata_o;
  logic [NUM_DRV-1:0][1:0] act_code_i, rcv_code_i;
  logic [NUM_DRV-1:0]      fast_en_i, dma_only_i, iordy_en_i, post_en_i;
  logic                    fast_nd_i;
  logic                    ior_no, iow_no, cs0_no, cs1_no, dd_oe_o;
  logic [AW-1:0]           da_o;
  logic [DW-1:0]           dd_o, dd_i;
  logic                    iordy_i;

  ide_pio_seq uut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_write_i(req_write_i),
    .req_drive_i(req_drive_i), .req_ctl_i(req_ctl_i), .req_addr_i(req_addr_i),
    .req_wdata_i(req_wdata_i), .done_o(done_o), .rdata_o(rdata_o),
    .act_code_i(act_code_i), .rcv_code_i(rcv_code_i), .fast_en_i(fast_en_i),
    .dma_only_i(dma_only_i), .iordy_en_i(iordy_en_i), .post_en_i(post_en_i),
    .fast_nd_i(fast_nd_i), .ior_no(ior_no), .iow_no(iow_no), .cs0_no(cs0_no),
    .cs1_no(cs1_no), .da_o(da_o), .dd_o(dd_o), .dd_oe_o(dd_oe_o), .dd_i(dd_i),
    .iordy_i(iordy_i)
  );

  typedef struct {
    int          width;
    int          gap;
    bit          wr;
    bit          ctl;
    int          addr;
    int          k;
    logic [15:0] data;
  } exp_t;

  typedef struct {
    bit          wr;
    bit          posted;
    logic [15:0] data;
  } done_t;

  exp_t  sq[$];
  done_t dq[$];
  int    n_chk = 0;
  int    n_bad = 0;
  int    last_rcv = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor + drive model (IORDY held low k clocks, read data from front item)
  bit          prev_lo, cur_lo, prev_ready, prev_cs0, prev_cs1;
  int          lo_cnt, hi_cnt;
  logic [2:0]  prev_da;
  exp_t        ce;
  done_t       cd;

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      prev_lo = 0; lo_cnt = 0; hi_cnt = 1000; prev_ready = 1;
      prev_cs0 = 1; prev_cs1 = 1; prev_da = '0;
      iordy_i = 1'b1; dd_i = '0;
    end else begin
      cur_lo = !ior_no || !iow_no;
      if (cur_lo && !prev_lo) begin
        lo_cnt = 1;
        if (sq.size() == 0) begin
          chk(0, "R2 strobe with no request", 1, 0);
        end else begin
          ce = sq[0];
          if (ce.gap >= 0) chk(hi_cnt == ce.gap, "R5 recovery gap", hi_cnt, ce.gap);
          chk(int'(prev_da) == ce.addr && prev_cs0 == ce.ctl && prev_cs1 == !ce.ctl,
              "R2 address setup", int'(prev_da), ce.addr);
          chk(!prev_ready, "R11 ready low in cycle", int'(prev_ready), 0);
          if (ce.wr)
            chk(!iow_no && ior_no && dd_oe_o && dd_o == ce.data, "R11 write strobe/data",
                int'(dd_o), int'(ce.data));
          else
            chk(!ior_no && iow_no && !dd_oe_o, "R11 read strobe", int'(dd_oe_o), 0);
        end
      end else if (cur_lo) begin
        lo_cnt++;
      end
      if (!cur_lo && prev_lo) begin
        if (sq.size() != 0) begin
          ce = sq.pop_front();
          chk(lo_cnt == ce.width, "R3 R4 R6 R7 R8 strobe width", lo_cnt, ce.width);
          chk(int'(da_o) == ce.addr && cs0_no == ce.ctl && cs1_no == !ce.ctl,
              "R2 address hold", int'(da_o), ce.addr);
        end
        hi_cnt = 1;
      end else if (!cur_lo) begin
        hi_cnt++;
      end
      if (done_o) begin
        if (dq.size() == 0) begin
          chk(0, "R9 spurious done", 1, 0);
        end else begin
          cd = dq.pop_front();
          if (cd.posted)
            chk(!cur_lo && !prev_lo && !cs0_no, "R10 posted done before strobe", int'(prev_lo), 0);
          else
            chk(!cur_lo && prev_lo, "R9 R10 done after strobe rise", int'(prev_lo), 1);
          if (!cd.wr) chk(rdata_o == cd.data, "R9 read data", int'(rdata_o), int'(cd.data));
        end
      end
      if (cur_lo && sq.size() != 0) iordy_i = (lo_cnt >= sq[0].k);
      else                          iordy_i = 1'b1;
      dd_i = (sq.size() != 0) ? sq[0].data : '0;
      prev_lo = cur_lo; prev_da = da_o; prev_cs0 = cs0_no; prev_cs1 = cs1_no;
      prev_ready = req_ready_o;
    end
  end

  task automatic issue(int drv, bit wr, bit ctl, int addr, bit chain);
    exp_t  e;
    done_t d;
    int    a, r;
    bit    dat, fast;
    logic [15:0] v;
    v    = 16'($urandom);
    dat  = !ctl && addr == 0;
    fast = dat ? (fast_en_i[drv] && !dma_only_i[drv]) : fast_nd_i;
    a    = fast ? 5 - int'(act_code_i[drv]) : 12;
    r    = fast ? 4 - int'(rcv_code_i[drv]) : 10;
    e.k     = int'($urandom_range(16, 1));
    e.width = iordy_en_i[drv] ? ((e.k > a) ? e.k : a) : a;
    e.gap   = chain ? last_rcv + 2 : -1;
    last_rcv = r;
    e.wr = wr; e.ctl = ctl; e.addr = addr; e.data = v;
    d.wr = wr; d.posted = wr && dat && post_en_i[drv]; d.data = v;
    sq.push_back(e);
    dq.push_back(d);
    req_valid_i = 1'b1; req_write_i = wr; req_drive_i = 1'(drv); req_ctl_i = ctl;
    req_addr_i = 3'(addr); req_wdata_i = v;
    while (!req_ready_o) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic drain();
    req_valid_i = 1'b0;
    while (sq.size() != 0 || dq.size() != 0) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
  endtask

  task automatic check_idle(string tag);
    chk(ior_no && iow_no && cs0_no && cs1_no, {tag, " strobes/selects high"},
        int'({ior_no, iow_no, cs0_no, cs1_no}), 15);
    chk(!done_o && req_ready_o, {tag, " done low, ready high"}, int'({done_o, req_ready_o}), 1);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL R11 watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    rst_ni = 1'b0; req_valid_i = 0; req_write_i = 0; req_drive_i = 0; req_ctl_i = 0;
    req_addr_i = '0; req_wdata_i = '0; act_code_i = '0; rcv_code_i = '0;
    fast_en_i = '0; dma_only_i = '0; iordy_en_i = '0; post_en_i = '0; fast_nd_i = 0;
    repeat (3) @(negedge clk_i);
    check_idle("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_idle("R1 after reset");

    // R3 compatible timing, R6 IORDY ignored when sampling disabled
    issue(0, 0, 0, 0, 0);
    issue(0, 1, 1, 6, 1);
    issue(1, 0, 0, 3, 1);
    issue(1, 1, 0, 0, 1);
    drain();

    // R4 R5 every active and recovery code on the data port
    fast_en_i[0] = 1'b1;
    for (int c = 0; c < 4; c++) begin
      act_code_i[0] = 2'(c);
      rcv_code_i[0] = 2'(3 - c);
      issue(0, 0, 0, 0, 0);
      issue(0, 1, 0, 0, 1);
      issue(0, 0, 0, 0, 1);
      drain();
    end

    // R6 IORDY sampling stretches the strobe
    fast_en_i[1] = 1'b1; act_code_i[1] = 2'd3; rcv_code_i[1] = 2'd2; iordy_en_i[1] = 1'b1;
    issue(1, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) issue(1, i[0], 0, 0, 1);
    issue(0, 0, 0, 0, 1);
    drain();
    iordy_en_i[1] = 1'b0;

    // R7 DMA-only enable forces compatible data-port timing
    dma_only_i[0] = 1'b1;
    issue(0, 0, 0, 0, 0);
    issue(1, 0, 0, 0, 1);
    issue(0, 1, 0, 0, 1);
    drain();
    dma_only_i[0] = 1'b0;

    // R8 fast timing for non-data registers
    act_code_i[0] = 2'd1; rcv_code_i[0] = 2'd2; fast_nd_i = 1'b1;
    issue(0, 0, 0, 2, 0);
    issue(0, 1, 1, 6, 1);
    issue(1, 0, 0, 7, 1);
    drain();
    fast_nd_i = 1'b0;
    issue(0, 0, 0, 2, 0);
    issue(0, 1, 1, 6, 1);
    drain();

    // R10 posting only on data-port writes with posting enabled
    post_en_i[0] = 1'b1;
    issue(0, 1, 0, 0, 0);
    issue(0, 1, 0, 5, 1);
    issue(1, 1, 0, 0, 1);
    issue(0, 0, 0, 0, 1);
    issue(0, 1, 0, 0, 1);
    drain();

    summary();
    $finish;
  end

endmodule